// File: doc/BRIEF.md
# Serial Flash Power-Down and Signature Responder

This block is the target-side serial-bus logic of a serial flash that handles only three things: entering deep power-down, leaving it, and reading back an 8-bit identification byte. It watches chip select, serial clock and serial data in, all sampled with the system clock. It drives serial data out together with an output enable, and the pad is meant to be high impedance whenever that enable is low. A busy input from the rest of the device marks an erase, program or status-write cycle in progress. While that input is high, the release/read-identification command is neither decoded nor acted on.

The block keeps one of three power states: stand-by, deep power-down, and a timed release that returns to stand-by after a parameterised number of system clock cycles. The release/read command (opcode ABh) is followed by three don't-care bytes. The identification byte is then sent MSB first, and it repeats for as long as the host keeps clocking with chip select low. The same command also works from stand-by, where no wait follows. The power-down command (opcode B9h) takes effect only if chip select rises exactly on the byte boundary that ends the opcode.

Top module: `spi_sig_responder`

## Requirements
- R1: After reset the block is in stand-by with `miso_oe` low, and a release/read command is accepted at once.
- R2: Input bits are taken on the rising edge of `sck`, MSB first. For opcode ABh followed by 24 don't-care bits, the signature byte `SIG` is driven MSB first. Each bit changes on a falling `sck` edge, and the first bit appears on the falling edge that follows the 32nd rising edge.
- R3: If clocking continues with `cs_n` low, the signature is sent again and again with no gap between copies.
- R4: `miso_oe` is low while the opcode and the don't-care bits are being shifted in, and it goes low after `cs_n` rises.
- R5: Opcode B9h enters deep power-down only when `cs_n` rises after exactly 8 rising `sck` edges. If it rises after any other count, the state does not change.
- R6: In deep power-down every opcode other than ABh is ignored. ABh still returns the signature, and the rise of `cs_n` that ends it starts a wait of `RELEASE_CYCLES` system clocks. Any command that is decoded during that wait is ignored and gives no output.
- R7: From stand-by, ABh returns the signature and leaves the block in stand-by, so the next command is accepted with no wait.
- R8: When `busy` is high while ABh is decoded, the command produces no output and does not change the power state.
- R9: A rise of `cs_n` in the middle of a byte discards the partial instruction, and the next selection starts counting at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data in |
| busy | input | 1 | High while an erase, program or status write is in progress |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |

## Verification
The bench ends the power-down opcode one bit late and checks that the block stays awake. A design that counted bytes loosely would fall asleep, and the release wait that follows would swallow the next command. It sends a release while asleep and a second one at once, and it repeats the release from stand-by. A design that started the wait in both cases, or in neither, would return or drop the second signature wrongly. It also applies the release with `busy` high and then tests that the device is still asleep, which catches a design that ignores busy or lets it disturb the state. Finally it leaves a byte incomplete before a full command, which exposes a bit counter that is not cleared on deselect.

// File: rtl/spi_sig_responder.sv
`timescale 1ns/1ps
module spi_sig_responder #(
  parameter logic [7:0] SIG = 8'h10,
  parameter int RELEASE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic busy,
  output logic miso,
  output logic miso_oe
);
  localparam logic [7:0] OP_READ  = 8'hAB;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam int WW = $clog2(RELEASE_CYCLES + 1);
  localparam logic [5:0] LAST_IN = 6'd32;
  localparam logic [1:0] P_STBY = 2'd0, P_SLEEP = 2'd1, P_WAKE = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_READ = 2'd1, C_SLEEP = 2'd2, C_IGN = 2'd3;

  logic [1:0] cs_q, mosi_q;
  logic [2:0] sck_q;
  logic cs_prev;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 2'b11; sck_q <= '0; mosi_q <= '0; cs_prev <= 1'b1;
    end else begin
      cs_q <= {cs_q[0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
      cs_prev <= cs_q[1];
    end

  wire cs_s     = cs_q[1];
  wire cs_rise  = cs_s & ~cs_prev;
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire mosi_s   = mosi_q[1];

  logic [5:0] cnt;
  logic [6:0] sh;
  logic [1:0] cmd, dec, pwr;
  logic [2:0] idx;
  logic [WW-1:0] wcnt;
  wire [7:0] op = {sh, mosi_s};

  always_comb begin
    dec = C_IGN;
    if (pwr != P_WAKE) begin
      if (op == OP_READ && !busy) dec = C_READ;
      else if (op == OP_SLEEP && pwr == P_STBY) dec = C_SLEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; sh <= '0; cmd <= C_NONE; idx <= '0; miso <= 1'b0; miso_oe <= 1'b0;
    end else if (cs_s) begin
      cnt <= '0; cmd <= C_NONE; idx <= '0; miso_oe <= 1'b0;
    end else begin
      if (sck_rise) begin
        if (cnt != LAST_IN) cnt <= cnt + 6'd1;
        if (cnt < 6'd8) sh <= {sh[5:0], mosi_s};
        if (cnt == 6'd7) cmd <= dec;
      end
      if (sck_fall && cmd == C_READ && cnt == LAST_IN) begin
        miso <= SIG[3'd7 - idx];
        miso_oe <= 1'b1;
        idx <= idx + 3'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwr <= P_STBY; wcnt <= '0;
    end else begin
      case (pwr)
        P_STBY:  if (cs_rise && cmd == C_SLEEP && cnt == 6'd8) pwr <= P_SLEEP;
        P_SLEEP: if (cs_rise && cmd == C_READ) begin
                   pwr <= P_WAKE; wcnt <= WW'(RELEASE_CYCLES);
                 end
        default: if (wcnt <= WW'(1)) pwr <= P_STBY;
                 else wcnt <= wcnt - WW'(1);
      endcase
    end
endmodule

module spi_sig_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic sck_rise,
  input logic sck_fall,
  input logic busy,
  input logic miso,
  input logic miso_oe,
  input logic [5:0] cnt,
  input logic [1:0] cmd,
  input logic [1:0] pwr
);
  assert_stable_between_falls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$past(sck_fall)) |-> $stable(miso));
  assert_quiet_during_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> cnt == 6'd32);
  assert_off_when_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso_oe);
  assert_sleep_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr == 2'd1 && $past(pwr) == 2'd0) |-> ($past(cnt) == 6'd8 && $past(cmd) == 2'd2));
  assert_silent_while_waking_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr == 2'd2 |-> !miso_oe);
  assert_busy_blocks_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_rise && !cs_s && cnt == 6'd7 && busy) |=> cmd != 2'd1);
endmodule

bind spi_sig_responder spi_sig_responder_chk u_chk (
  .clk, .rst_n, .cs_s, .sck_rise, .sck_fall, .busy, .miso, .miso_oe, .cnt, .cmd, .pwr
);

// File: tb/test_spi_sig_responder.sv
`timescale 1ns/1ps
module test_spi_sig_responder;
  localparam logic [7:0] SIG = 8'hC6;
  localparam int REL = 400;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic miso, miso_oe;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_sig_responder #(.SIG(SIG), .RELEASE_CYCLES(REL)) i_spi_sig_responder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .busy(busy),
    .miso(miso), .miso_oe(miso_oe));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic o_oe, output logic o_d);
    mosi = b; #40;
    o_oe = miso_oe; o_d = miso;
    sck = 1'b1; #40; sck = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] op, input int extra, input int nout,
                         input bit exp_sig, input string req);
    logic oe, d;
    cs_n = 1'b0; #40;
    for (int i = 0; i < 8 + extra; i++) begin
      xbit(i < 8 ? op[7-i] : 1'b0, oe, d);
      chk(oe == 1'b0, "R4", $sformatf("oe during input bit %0d", i), int'(oe), 0);
    end
    for (int i = 0; i < nout; i++) begin
      xbit(1'b0, oe, d);
      if (exp_sig)
        chk(oe == 1'b1 && d == SIG[7 - (i % 8)], req, $sformatf("{oe,bit} %0d", i),
            int'({oe, d}), int'({1'b1, SIG[7 - (i % 8)]}));
      else
        chk(oe == 1'b0, req, $sformatf("oe on ignored cmd bit %0d", i), int'(oe), 0);
    end
    #40; cs_n = 1'b1; #40;
    chk(miso_oe == 1'b0, "R4", "oe after deselect", int'(miso_oe), 0);
    #40;
  endtask

  task automatic partial(input logic [7:0] op, input int n);
    logic oe, d;
    cs_n = 1'b0; #40;
    for (int i = 0; i < n; i++) xbit(op[7-i], oe, d);
    #40; cs_n = 1'b1; #80;
  endtask

  task automatic wait_release();
    #(REL * 5 + 200);
  endtask

  task automatic t_reset();
    chk(miso_oe == 1'b0, "R1", "oe in reset", int'(miso_oe), 0);
    #50; rst_n = 1'b1; #50;
    chk(miso_oe == 1'b0, "R1", "oe after reset", int'(miso_oe), 0);
    run_cmd(8'hAB, 24, 8, 1'b1, "R1");
  endtask

  task automatic t_standby_read();
    run_cmd(8'hAB, 24, 8, 1'b1, "R2");
    run_cmd(8'hAB, 24, 24, 1'b1, "R3");
    run_cmd(8'hAB, 24, 8, 1'b1, "R7");
  endtask

  task automatic t_sleep();
    run_cmd(8'hB9, 0, 0, 1'b0, "R5");
    run_cmd(8'h9F, 24, 8, 1'b0, "R6");
    run_cmd(8'hAB, 24, 8, 1'b1, "R6");
    run_cmd(8'hAB, 24, 8, 1'b0, "R6");
    wait_release();
    run_cmd(8'hAB, 24, 8, 1'b1, "R6");
  endtask

  task automatic t_off_boundary();
    run_cmd(8'hB9, 1, 0, 1'b0, "R5");
    run_cmd(8'hAB, 24, 8, 1'b1, "R5");
    run_cmd(8'hAB, 24, 8, 1'b1, "R5");
  endtask

  task automatic t_busy();
    run_cmd(8'hB9, 0, 0, 1'b0, "R8");
    busy = 1'b1;
    run_cmd(8'hAB, 24, 8, 1'b0, "R8");
    busy = 1'b0;
    run_cmd(8'hAB, 24, 8, 1'b1, "R8");
    run_cmd(8'hAB, 24, 8, 1'b0, "R8");
    wait_release();
  endtask

  task automatic t_abort();
    partial(8'hAB, 4);
    run_cmd(8'hAB, 24, 8, 1'b1, "R9");
    partial(8'h00, 3);
    run_cmd(8'hB9, 0, 0, 1'b0, "R9");
    run_cmd(8'hAB, 24, 8, 1'b1, "R9");
    run_cmd(8'hAB, 24, 8, 1'b0, "R9");
    wait_release();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_standby_read();
    t_sleep();
    t_off_boundary();
    t_busy();
    t_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule